// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer with Rule Monitor

This block lets a simple in-order 32-bit core repeat a code region without branch instructions. It holds two loop contexts. Each context has a first-instruction address, a last-instruction address and a remaining-iteration count. Software programs each field on its own through a register-write port. Every cycle the core presents the address of the instruction it is executing, and the block returns the address to fetch next. That address is either the next sequential word or, when a loop must repeat, the first address of that loop.

A context whose count is zero is dormant. Code lying between its bounds runs as plain sequential code: there is no redirect and no rule checking. When the count goes from zero to non-zero, the block takes a snapshot of the bounds. Taken branches are then checked against that snapshot, so that an active body is entered only through its first instruction. A write to the bounds of an active context is also a breach. Every breach raises a flag. When the enforce input is high, the flag also becomes an illegal-instruction trap and the offending register write is dropped. Context 0 is the inner loop and wins when both contexts end at the same address.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, all bounds and counts of both contexts are zero. With exe_valid high, next_pc equals exe_pc+4, and redirect, viol_flag and illegal_trap are all low.
- R2: A write with wr_en high updates the field of context wr_set chosen by wr_kind: 0 is the count, 1 the first address, 2 the last address. Code 3 changes nothing.
- R3: A context is active exactly when its count is non-zero. Its body is every address a with first <= a <= last.
- R4: When exe_valid is high, exe_pc equals the last address of an active context and its count is above one, the count drops by one, redirect is high and next_pc equals that context's first address.
- R5: When exe_pc equals the last address of an active context whose count is one, the count becomes zero, redirect is low and next_pc is exe_pc+4.
- R6: With a count of zero, a context causes no redirect and no flag, even for branches into its address range.
- R7: Writing the first or last address of a context whose count is non-zero raises viol_flag in that cycle.
- R8: With exe_valid and br_taken high, a target t with ref_first < t <= ref_last of an active context raises viol_flag. A target equal to ref_first does not.
- R9: The reference bounds used by R8 are captured only in the cycle where the count goes from zero to non-zero. Later bound writes do not move them.
- R10: illegal_trap equals viol_flag while enforce is high and stays low otherwise. Any register write in a trapping cycle is discarded. With enforce low, a flagged write still takes effect.
- R11: Writing first, then last, then count never raises a flag or a redirect, even while the executing addresses lie inside the new bounds.
- R12: If both contexts end at exe_pc, context 0 acts. Context 1 is decremented and may redirect only when context 0 falls through at that address.
- R13: With exe_valid low there is no redirect, no decrement and no branch check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Loop register write strobe |
| wr_set | input | 1 | Context selected by the write |
| wr_kind | input | 2 | Field: 0 count, 1 first, 2 last, 3 none |
| wr_data | input | 32 | Write value |
| exe_valid | input | 1 | An instruction is executing this cycle |
| exe_pc | input | 32 | Address of the executing instruction |
| br_taken | input | 1 | Executing instruction is a taken branch or jump |
| br_target | input | 32 | Target of that branch |
| enforce | input | 1 | Turn breaches into traps |
| next_pc | output | 32 | Next fetch address |
| redirect | output | 1 | next_pc is a loop first address |
| viol_flag | output | 1 | Programming rule breach this cycle |
| illegal_trap | output | 1 | Breach raised as illegal instruction |

## Verification
Two functions can fall in the same cycle: the loop-back decision of context 0 and that of context 1, when both share one last address. The bench builds a nested pair with identical last addresses. It re-arms the inner count inside the outer body and walks the addresses so that the inner loop repeats once, falls through and hands the same cycle to the outer loop. A behavioural model compares every cycle, and explicit checks pin next_pc to the inner first address, then the outer first address, then the sequential word. A second overlap is a trapped bound write landing on a context that must still loop to its old first address.

// File: rtl/hwl_pkg.sv
`timescale 1ns/1ps
package hwl_pkg;
  localparam int NUM_SETS = 2;

  typedef enum logic [1:0] {
    WK_COUNT = 2'd0,
    WK_START = 2'd1,
    WK_END   = 2'd2,
    WK_NONE  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/hwl_set.sv
`timescale 1ns/1ps
// One loop context: bounds, count, activation snapshot and end match.
module hwl_set #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exe_valid,
  input  logic [AW-1:0] exe_pc,
  input  logic          wr_cnt,
  input  logic          wr_start,
  input  logic          wr_end,
  input  logic [AW-1:0] wr_data,
  input  logic          dec,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] ref_start_o,
  output logic [AW-1:0] ref_end_o,
  output logic          active_o,
  output logic          hit_o,
  output logic          last_o
);
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [AW-1:0] start_q, start_d, end_q, end_d, rs_q, re_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en, arm;

  always_comb begin
    start_d = wr_start ? wr_data : start_q;
    end_d   = wr_end   ? wr_data : end_q;
    cnt_en  = wr_cnt | dec;
    cnt_d   = cnt_q;
    if (wr_cnt)   cnt_d = wr_data[CW-1:0];
    else if (dec) cnt_d = cnt_q - CNT_ONE;
    arm = (cnt_q == '0) && (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      rs_q    <= '0;
      re_q    <= '0;
    end else begin
      if (wr_start) start_q <= start_d;
      if (wr_end)   end_q   <= end_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (arm) begin
        rs_q <= start_q;
        re_q <= end_q;
      end
    end
  end

  assign start_o     = start_q;
  assign ref_start_o = rs_q;
  assign ref_end_o   = re_q;
  assign active_o    = (cnt_q != '0);
  assign hit_o       = exe_valid && active_o && (exe_pc == end_q);
  assign last_o      = (cnt_q == CNT_ONE);

  // R4: without a count write the count only holds or steps down by one
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - CNT_ONE));

  // R5: a granted decrement on the last pass leaves the context dormant
  p_last_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && (cnt_q == CNT_ONE) && !wr_cnt) |=> (cnt_q == '0));

  // R9: the snapshot reflects the bounds seen at activation
  p_arm_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != '0) && ($past(cnt_q) == '0)) |->
      (rs_q == $past(start_q)) && (re_q == $past(end_q)));
endmodule

// File: rtl/hwl_seq.sv
`timescale 1ns/1ps
// Loop-back arbitration: context 0 is the inner loop.
module hwl_seq #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic                exe_valid,
  input  logic [AW-1:0]       exe_pc,
  input  logic [1:0]          hit,
  input  logic [1:0]          last,
  input  logic [1:0][AW-1:0]  starts,
  output logic [1:0]          dec,
  output logic                redirect,
  output logic [AW-1:0]       next_pc
);
  logic red0, red1, inner_hold;

  always_comb begin
    inner_hold = hit[0] && !last[0];
    dec[0]     = hit[0];
    dec[1]     = hit[1] && !inner_hold;
    red0       = inner_hold;
    red1       = dec[1] && !last[1];
    redirect   = red0 | red1;
    if (red0)      next_pc = starts[0];
    else if (red1) next_pc = starts[1];
    else           next_pc = exe_pc + AW'(STEP);
  end

  always_comb begin
    // R4: a loop-back always lands on a context first address
    if (redirect) begin
      p_redir_target_r4: assert ((next_pc == starts[0]) || (next_pc == starts[1]))
        else $error("redirect off any first address");
    end
    // R12: outer loop acts at a shared end only after inner fall-through
    if (dec[1] && hit[0]) begin
      p_outer_gated_r12: assert (last[0]) else $error("outer stepped over inner");
    end
    // R13: no loop action without an executing instruction
    if (!exe_valid) begin
      p_idle_quiet_r13: assert (!redirect && (dec == 2'b00)) else $error("idle action");
    end
  end
endmodule

// File: rtl/hwl_rule_check.sv
`timescale 1ns/1ps
// Programming rule monitor: bound writes on live contexts and side entries.
module hwl_rule_check #(
  parameter int AW = 32
) (
  input  logic               wr_en,
  input  logic [1:0]         wr_kind,
  input  logic               wr_set,
  input  logic               exe_valid,
  input  logic               br_taken,
  input  logic [AW-1:0]      br_target,
  input  logic               enforce,
  input  logic [1:0]         active,
  input  logic [1:0][AW-1:0] ref_start,
  input  logic [1:0][AW-1:0] ref_end,
  output logic               viol,
  output logic               trap
);
  import hwl_pkg::*;

  logic [1:0] side_entry;
  logic       bound_wr, wr_viol, br_viol;

  for (genvar i = 0; i < NUM_SETS; i++) begin : g_entry
    assign side_entry[i] = active[i] && (br_target > ref_start[i])
                           && (br_target <= ref_end[i]);
  end

  always_comb begin
    bound_wr = wr_en && ((wr_kind == WK_START) || (wr_kind == WK_END));
    wr_viol  = bound_wr && active[wr_set];
    br_viol  = exe_valid && br_taken && (side_entry != 2'b00);
    viol     = wr_viol | br_viol;
    trap     = viol & enforce;
  end

  always_comb begin
    // R6: dormant contexts never produce a flag
    if (active == 2'b00) begin
      p_dormant_silent_r6: assert (!viol) else $error("flag with both dormant");
    end
    // R8: entering at the first address is never a breach
    if (!bound_wr && ((br_target == ref_start[0]) || !active[0])
        && ((br_target == ref_start[1]) || !active[1])) begin
      p_first_entry_ok_r8: assert (!viol) else $error("entry at first flagged");
    end
  end
endmodule

// File: rtl/hwloop_ctrl.sv
`timescale 1ns/1ps
module hwloop_ctrl #(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_set,
  input  logic [1:0]    wr_kind,
  input  logic [AW-1:0] wr_data,
  input  logic          exe_valid,
  input  logic [AW-1:0] exe_pc,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  input  logic          enforce,
  output logic [AW-1:0] next_pc,
  output logic          redirect,
  output logic          viol_flag,
  output logic          illegal_trap
);
  import hwl_pkg::*;

  logic [1:0]          active_w, hit_w, last_w, dec_w;
  logic [1:0][AW-1:0]  start_w, rs_w, re_w;
  logic                wr_ok;

  assign wr_ok = wr_en && !illegal_trap;

  for (genvar i = 0; i < NUM_SETS; i++) begin : g_set
    logic sel;
    assign sel = wr_ok && (wr_set == i[0]);
    hwl_set #(.AW(AW), .CW(CW)) u_set (
      .clk        (clk),
      .rst_n      (rst_n),
      .exe_valid  (exe_valid),
      .exe_pc     (exe_pc),
      .wr_cnt     (sel && (wr_kind == WK_COUNT)),
      .wr_start   (sel && (wr_kind == WK_START)),
      .wr_end     (sel && (wr_kind == WK_END)),
      .wr_data    (wr_data),
      .dec        (dec_w[i]),
      .start_o    (start_w[i]),
      .ref_start_o(rs_w[i]),
      .ref_end_o  (re_w[i]),
      .active_o   (active_w[i]),
      .hit_o      (hit_w[i]),
      .last_o     (last_w[i])
    );
  end

  hwl_seq #(.AW(AW), .STEP(STEP)) u_seq (
    .exe_valid(exe_valid),
    .exe_pc   (exe_pc),
    .hit      (hit_w),
    .last     (last_w),
    .starts   (start_w),
    .dec      (dec_w),
    .redirect (redirect),
    .next_pc  (next_pc)
  );

  hwl_rule_check #(.AW(AW)) u_chk (
    .wr_en    (wr_en),
    .wr_kind  (wr_kind),
    .wr_set   (wr_set),
    .exe_valid(exe_valid),
    .br_taken (br_taken),
    .br_target(br_target),
    .enforce  (enforce),
    .active   (active_w),
    .ref_start(rs_w),
    .ref_end  (re_w),
    .viol     (viol_flag),
    .trap     (illegal_trap)
  );

  // R10: a trapped first-address write leaves the register untouched
  p_trap_drops_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_trap && wr_en && (wr_kind == WK_START) && !wr_set)
      |=> (start_w[0] == $past(start_w[0])));

  // R7: a bound write on a live context is always reported
  p_live_bound_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_kind == WK_END) && active_w[wr_set]) |-> viol_flag);
endmodule

// File: tb/hwloop_ctrl_tb_top.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_set, exe_valid, br_taken, enforce;
  logic [1:0]  wr_kind;
  logic [31:0] wr_data, exe_pc, br_target;
  logic [31:0] next_pc;
  logic        redirect, viol_flag, illegal_trap;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_cnt [2];
  logic [31:0] m_st  [2];
  logic [31:0] m_en  [2];
  logic [31:0] m_rs  [2];
  logic [31:0] m_re  [2];

  logic [31:0] s_next;
  logic        s_red, s_viol, s_trap;

  always #10 clk = ~clk;

  hwloop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .wr_kind(wr_kind),
    .wr_data(wr_data), .exe_valid(exe_valid), .exe_pc(exe_pc), .br_taken(br_taken),
    .br_target(br_target), .enforce(enforce), .next_pc(next_pc), .redirect(redirect),
    .viol_flag(viol_flag), .illegal_trap(illegal_trap)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Compare at the falling edge, then advance the model to the next rising edge.
  task automatic step(input string tag);
    logic [31:0] e_next, n_cnt0, n_cnt1;
    logic e_red, e_v, e_t, wv, bv, h0, h1, g1;
    int s;
    @(negedge clk);
    s  = int'(wr_set);
    wv = wr_en && (wr_kind == 2'd1 || wr_kind == 2'd2) && (m_cnt[s] != 0);
    bv = 1'b0;
    for (int i = 0; i < 2; i++)
      if (exe_valid && br_taken && m_cnt[i] != 0 && br_target > m_rs[i] && br_target <= m_re[i])
        bv = 1'b1;
    e_v = wv | bv;
    e_t = e_v & enforce;
    h0 = exe_valid && m_cnt[0] != 0 && exe_pc == m_en[0];
    h1 = exe_valid && m_cnt[1] != 0 && exe_pc == m_en[1];
    n_cnt0 = m_cnt[0];
    n_cnt1 = m_cnt[1];
    e_red = 1'b0;
    e_next = exe_pc + 32'd4;
    g1 = h1 && !(h0 && m_cnt[0] > 1);
    if (h0) begin
      n_cnt0 = m_cnt[0] - 1;
      if (m_cnt[0] > 1) begin e_red = 1'b1; e_next = m_st[0]; end
    end
    if (g1) begin
      n_cnt1 = m_cnt[1] - 1;
      if (m_cnt[1] > 1) begin e_red = 1'b1; e_next = m_st[1]; end
    end
    s_next = next_pc; s_red = redirect; s_viol = viol_flag; s_trap = illegal_trap;
    chk(tag, "next_pc", next_pc, e_next);
    chk(tag, "redirect", {31'd0, redirect}, {31'd0, e_red});
    chk(tag, "viol_flag", {31'd0, viol_flag}, {31'd0, e_v});
    chk(tag, "illegal_trap", {31'd0, illegal_trap}, {31'd0, e_t});
    if (rst_n) begin
      if (wr_en && !e_t) begin
        if (wr_kind == 2'd0) begin
          if (s == 0) n_cnt0 = wr_data; else n_cnt1 = wr_data;
        end
      end
      if (m_cnt[0] == 0 && n_cnt0 != 0) begin m_rs[0] = m_st[0]; m_re[0] = m_en[0]; end
      if (m_cnt[1] == 0 && n_cnt1 != 0) begin m_rs[1] = m_st[1]; m_re[1] = m_en[1]; end
      if (wr_en && !e_t && wr_kind == 2'd1) m_st[s] = wr_data;
      if (wr_en && !e_t && wr_kind == 2'd2) m_en[s] = wr_data;
      m_cnt[0] = n_cnt0;
      m_cnt[1] = n_cnt1;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    wr_en = 1'b0; br_taken = 1'b0; exe_valid = 1'b0; wr_kind = 2'd3;
  endtask

  task automatic exec(input logic [31:0] pc, input string tag);
    quiet(); exe_valid = 1'b1; exe_pc = pc; step(tag);
  endtask

  task automatic wr(input logic set, input logic [1:0] kind, input logic [31:0] d,
                    input logic [31:0] pc, input string tag);
    quiet(); exe_valid = 1'b1; exe_pc = pc;
    wr_en = 1'b1; wr_set = set; wr_kind = kind; wr_data = d;
    step(tag);
  endtask

  task automatic br(input logic [31:0] pc, input logic [31:0] tgt, input string tag);
    quiet(); exe_valid = 1'b1; exe_pc = pc; br_taken = 1'b1; br_target = tgt;
    step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_st[i] = 0; m_en[i] = 0; m_rs[i] = 0; m_re[i] = 0;
    end
    rst_n = 1'b0; enforce = 1'b0; wr_set = 1'b0; wr_data = 0;
    exe_pc = 32'h40; br_target = 0;
    quiet();
    exe_valid = 1'b1;
    step("R1");
    step("R1");
    rst_n = 1'b1;

    // R1: dormant after reset
    exec(32'h0, "R1");
    chk("R1", "reset next", s_next, 32'h4);
    chk("R1", "reset redirect", {31'd0, s_red}, 32'd0);

    // R2: reserved kind writes nothing
    wr(1'b0, 2'd3, 32'd5, 32'h10, "R2");
    exec(32'h0, "R2");
    chk("R2", "no count from kind 3", {31'd0, s_red}, 32'd0);

    // R11: first, last, count while executing inside new bounds
    wr(1'b0, 2'd1, 32'h100, 32'h104, "R11");
    chk("R11", "flag after first", {31'd0, s_viol}, 32'd0);
    wr(1'b0, 2'd2, 32'h10C, 32'h108, "R11");
    chk("R11", "flag after last", {31'd0, s_viol}, 32'd0);
    wr(1'b0, 2'd0, 32'd3, 32'h0F8, "R11");
    chk("R11", "no redirect", {31'd0, s_red}, 32'd0);

    // R3 R4 R5: three passes over the body
    for (int it = 0; it < 3; it++) begin
      exec(32'h100, "R3"); exec(32'h104, "R3"); exec(32'h108, "R3");
      exec(32'h10C, it < 2 ? "R4" : "R5");
      if (it < 2) chk("R4", "loop back", s_next, 32'h100);
      else        chk("R5", "fall through", s_next, 32'h110);
    end

    // R6: dormant context ignores side entry
    br(32'h50, 32'h108, "R6");
    chk("R6", "dormant branch", {31'd0, s_viol}, 32'd0);
    exec(32'h10C, "R6");
    chk("R6", "dormant end", {31'd0, s_red}, 32'd0);

    // R8: side entry on an active context
    wr(1'b0, 2'd0, 32'd2, 32'h0F8, "R8");
    br(32'h50, 32'h108, "R8");
    chk("R8", "inside target", {31'd0, s_viol}, 32'd1);
    br(32'h50, 32'h100, "R8");
    chk("R8", "first target", {31'd0, s_viol}, 32'd0);
    br(32'h50, 32'h10C, "R8");
    chk("R8", "last target", {31'd0, s_viol}, 32'd1);
    br(32'h50, 32'h110, "R8");
    chk("R8", "outside target", {31'd0, s_viol}, 32'd0);

    // R7 R10: reported-only bound write takes effect
    wr(1'b0, 2'd2, 32'h11C, 32'h60, "R7");
    chk("R7", "live last write", {31'd0, s_viol}, 32'd1);
    chk("R10", "no trap unenforced", {31'd0, s_trap}, 32'd0);
    exec(32'h10C, "R10");
    chk("R10", "old last inert", {31'd0, s_red}, 32'd0);

    // R9: snapshot bounds stay at activation values
    br(32'h50, 32'h114, "R9");
    chk("R9", "new range ignored", {31'd0, s_viol}, 32'd0);
    br(32'h50, 32'h104, "R9");
    chk("R9", "old range flagged", {31'd0, s_viol}, 32'd1);
    exec(32'h11C, "R10");
    chk("R10", "new last loops", s_next, 32'h100);

    // R10: enforced write traps and is dropped
    enforce = 1'b1;
    wr(1'b0, 2'd1, 32'h80, 32'h60, "R10");
    chk("R10", "trap raised", {31'd0, s_trap}, 32'd1);
    wr(1'b0, 2'd0, 32'd2, 32'h64, "R10");
    exec(32'h11C, "R10");
    chk("R10", "first kept", s_next, 32'h100);
    exec(32'h11C, "R10");
    enforce = 1'b0;

    // R13: idle cycle at the last address
    wr(1'b0, 2'd0, 32'd2, 32'h64, "R13");
    quiet(); exe_pc = 32'h11C; step("R13");
    chk("R13", "idle no redirect", {31'd0, s_red}, 32'd0);
    exec(32'h11C, "R13");
    chk("R13", "valid loops", s_next, 32'h100);
    exec(32'h11C, "R13");

    // R12: nested contexts sharing one last address
    wr(1'b0, 2'd1, 32'h200, 32'h70, "R12");
    wr(1'b0, 2'd2, 32'h20C, 32'h74, "R12");
    wr(1'b1, 2'd1, 32'h1F0, 32'h78, "R12");
    wr(1'b1, 2'd2, 32'h20C, 32'h7C, "R12");
    wr(1'b1, 2'd0, 32'd2, 32'h80, "R12");
    for (int ot = 0; ot < 2; ot++) begin
      exec(32'h1F0, "R12");
      wr(1'b0, 2'd0, 32'd2, 32'h1F4, "R12");
      for (int in = 0; in < 2; in++) begin
        exec(32'h200, "R12"); exec(32'h204, "R12"); exec(32'h208, "R12");
        exec(32'h20C, "R12");
        if (in == 0)      chk("R12", "inner loops", s_next, 32'h200);
        else if (ot == 0) chk("R12", "outer loops", s_next, 32'h1F0);
        else              chk("R12", "both exit", s_next, 32'h210);
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule